// File: doc/BRIEF.md
# Node Identity Capture with Parity Lockout

This block holds the identity of one node: a bus identifier and a 6-bit module identifier. Both are loaded only while the external initialization input is high. The bus identifier comes from the memory-bus data pins and is guarded by two even-parity bits. The module identifier comes from the processor-side bus and carries its own even-parity bit. That parity bit is stored next to the identifier in one register.

The block checks the bus parity on every sample taken during initialization. It checks the stored module word on every cycle, including normal operation. Either failure locks the node out. Output enable and address-match enable drop, the identity outputs read zero, and a lock flag rises. Only a new initialization window can clear the lock, and only if its last captured sample is clean.

The identity inputs are level-sampled and qualified by the initialization input. The node never refuses a sample, so there is no valid/ready handshake and no back-pressure. Every cycle in which initialization is high overwrites the registers.

Top module: `node_id_guard`

## Requirements
- R1: After reset, `lock_o`, `out_en_o` and `addr_match_en_o` are 0, and both identity outputs read 0.
- R2: The identity registers change only on clock edges where `init_i` is high. Data and parity changes while `init_i` is low have no effect on outputs, and in this state bad bus parity does not lock the node.
- R3: The bus identifier is `mem_data_i[BUS_ID_W-1:0]`. `mem_par_i[0]` is the even-parity bit of the lower half, bits [3:0] by default. `mem_par_i[1]` is the even-parity bit of the upper half, bits [7:4] by default. A half is correct when the XOR of its bits and its parity bit is 0.
- R4: The module identifier is `mod_data_i[5:0]` and its even-parity bit is `mod_data_i[6]`. The 7-bit word is correct when its XOR is 0, and it is stored as one word.
- R5: A bus parity error on any edge where `init_i` is high sets `lock_o` at that edge, so it shows in the cycle after the sample.
- R6: The stored module word is checked on every cycle. A single flipped bit, even during normal operation, sets `lock_o` on the next edge.
- R7: Whenever the node is not in normal operation, `out_en_o` and `addr_match_en_o` are 0 and the identity outputs read 0. This includes while locked and during initialization.
- R8: With `init_i` low, the lock holds no matter what the data inputs do.
- R9: When `init_i` falls, the node judges the last captured sample. On the first edge with `init_i` low it enters normal operation if every parity check passes: `lock_o` 0, enables 1, stored identifiers shown. Otherwise it is locked.
- R10: Raising `init_i` during normal operation drops both enables on the next edge without setting the lock.
- R11: A window that starts with a bad sample and ends with a good one leaves `lock_o` at 1 until `init_i` falls, then returns to normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | External initialization; registers load while high |
| mem_data_i | input | MEM_W (16) | Memory-bus data pins carrying the bus identifier |
| mem_par_i | input | 2 | Memory-bus even-parity bits, one per half of the bus ID |
| mod_data_i | input | MOD_ID_W+1 (7) | Module identifier with its even-parity bit on top |
| bus_id_o | output | BUS_ID_W (8) | Stored bus identifier, zero unless running |
| mod_id_o | output | MOD_ID_W (6) | Stored module identifier, zero unless running |
| addr_match_en_o | output | 1 | Address recognition enable |
| out_en_o | output | 1 | Output drivers enable |
| lock_o | output | 1 | Registered lockout status |

## Verification
The hardest case to reach is an upset in the stored module word during normal operation. The ports cannot write that register while `init_i` is low. To create it, the bench forces one bit of the stored word for a cycle. It then confirms the lock, shows that the lock survives the release and later input activity, and clears it with a clean window. A second hard case is a window that holds a bad sample and then a good one. Here the bench drives both samples back to back and checks that the lock persists until the window closes.

// File: rtl/id_guard_pkg.sv
package id_guard_pkg;

  // Operating mode of the node
  typedef enum logic [1:0] {
    NM_RESET = 2'd0,  // never initialized
    NM_LOAD  = 2'd1,  // initialization window open, no fault seen
    NM_RUN   = 2'd2,  // normal operation
    NM_LOCK  = 2'd3   // parity lockout
  } node_mode_e;

  localparam int unsigned BUS_PAR_W = 2;

endpackage

// File: rtl/bus_id_capture.sv
module bus_id_capture
  import id_guard_pkg::*;
#(
  parameter int unsigned MEM_W      = 16,
  parameter int unsigned BUS_ID_W   = 8,
  parameter int unsigned BUS_ID_LSB = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [MEM_W-1:0]      mem_data_i,
  input  logic [BUS_PAR_W-1:0]  mem_par_i,
  output logic [BUS_ID_W-1:0]   bus_id_o,
  output logic                  live_err_o,
  output logic                  stored_ok_o
);

  localparam int unsigned HALF_W = BUS_ID_W / BUS_PAR_W;

  logic [BUS_ID_W-1:0]  field_live;
  logic [BUS_ID_W-1:0]  id_q;
  logic [BUS_PAR_W-1:0] par_q;
  logic [BUS_PAR_W-1:0] live_bad;
  logic [BUS_PAR_W-1:0] stored_bad;

  assign field_live = mem_data_i[BUS_ID_LSB +: BUS_ID_W];

  // one even-parity check per half, for the live pins and for the stored copy
  for (genvar h = 0; h < BUS_PAR_W; h++) begin : g_half
    assign live_bad[h]   = ^{field_live[h*HALF_W +: HALF_W], mem_par_i[h]};
    assign stored_bad[h] = ^{id_q[h*HALF_W +: HALF_W], par_q[h]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      par_q <= '0;
    end else if (load_i) begin
      id_q  <= field_live;
      par_q <= mem_par_i;
    end
  end

  assign bus_id_o    = id_q;
  assign live_err_o  = load_i && (|live_bad);
  assign stored_ok_o = ~(|stored_bad);

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(id_q)); // R2

  AST_BUS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (id_q == $past(field_live))); // R3

endmodule

// File: rtl/mod_id_store.sv
module mod_id_store #(
  parameter int unsigned MOD_ID_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [MOD_ID_W:0]   mod_data_i,
  output logic [MOD_ID_W-1:0] mod_id_o,
  output logic                par_err_o
);

  localparam int unsigned WORD_W = MOD_ID_W + 1;

  // identifier and its parity bit live in one word
  logic [WORD_W-1:0] stored_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= '0;
    end else if (load_i) begin
      stored_q <= mod_data_i;
    end
  end

  assign mod_id_o  = stored_q[MOD_ID_W-1:0];
  // checked every cycle, not only at load
  assign par_err_o = ^stored_q;

  AST_MOD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (stored_q == $past(mod_data_i))); // R4

endmodule

// File: rtl/node_mode_fsm.sv
module node_mode_fsm
  import id_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic bus_live_err_i,
  input  logic mod_err_i,
  input  logic bus_stored_ok_i,
  output logic run_o,
  output logic lock_o
);

  node_mode_e mode_q, mode_d;
  logic       init_d_q;
  logic       fault_now;
  logic       window_end;
  logic       capture_clean;

  assign fault_now     = bus_live_err_i || mod_err_i;
  assign window_end    = init_d_q && !init_i;
  assign capture_clean = bus_stored_ok_i && !mod_err_i;

  always_comb begin
    mode_d = mode_q;
    if (fault_now) begin
      mode_d = NM_LOCK;
    end else if (init_i) begin
      if (mode_q != NM_LOCK) mode_d = NM_LOAD;
    end else if (window_end) begin
      mode_d = capture_clean ? NM_RUN : NM_LOCK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= NM_RESET;
      init_d_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      init_d_q <= init_i;
    end
  end

  assign run_o  = (mode_q == NM_RUN);
  assign lock_o = (mode_q == NM_LOCK);

  AST_BUS_ERR_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_live_err_i |=> lock_o); // R5

  AST_MOD_ERR_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mod_err_i |=> lock_o); // R6

  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !init_i && !init_d_q) |=> lock_o); // R8

  AST_INIT_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> !run_o); // R10

endmodule

// File: rtl/node_id_guard.sv
module node_id_guard
  import id_guard_pkg::*;
#(
  parameter int unsigned MEM_W      = 16,
  parameter int unsigned BUS_ID_W   = 8,
  parameter int unsigned BUS_ID_LSB = 0,
  parameter int unsigned MOD_ID_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_i,
  input  logic [MEM_W-1:0]     mem_data_i,
  input  logic [1:0]           mem_par_i,
  input  logic [MOD_ID_W:0]    mod_data_i,
  output logic [BUS_ID_W-1:0]  bus_id_o,
  output logic [MOD_ID_W-1:0]  mod_id_o,
  output logic                 addr_match_en_o,
  output logic                 out_en_o,
  output logic                 lock_o
);

  logic [BUS_ID_W-1:0] bus_id_raw;
  logic [MOD_ID_W-1:0] mod_id_raw;
  logic                bus_live_err;
  logic                bus_stored_ok;
  logic                mod_err;
  logic                run;

  bus_id_capture #(
    .MEM_W      (MEM_W),
    .BUS_ID_W   (BUS_ID_W),
    .BUS_ID_LSB (BUS_ID_LSB)
  ) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (init_i),
    .mem_data_i  (mem_data_i),
    .mem_par_i   (mem_par_i),
    .bus_id_o    (bus_id_raw),
    .live_err_o  (bus_live_err),
    .stored_ok_o (bus_stored_ok)
  );

  mod_id_store #(
    .MOD_ID_W (MOD_ID_W)
  ) u_mod (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (init_i),
    .mod_data_i (mod_data_i),
    .mod_id_o   (mod_id_raw),
    .par_err_o  (mod_err)
  );

  node_mode_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .init_i          (init_i),
    .bus_live_err_i  (bus_live_err),
    .mod_err_i       (mod_err),
    .bus_stored_ok_i (bus_stored_ok),
    .run_o           (run),
    .lock_o          (lock_o)
  );

  // the node vanishes from the system unless it is running
  assign out_en_o        = run;
  assign addr_match_en_o = run;
  assign bus_id_o        = run ? bus_id_raw : '0;
  assign mod_id_o        = run ? mod_id_raw : '0;

  AST_QUIET_UNLESS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_o |-> (bus_id_o == '0 && mod_id_o == '0 && !addr_match_en_o)); // R7

endmodule

// File: tb/tb_node_id_guard.sv
module tb_node_id_guard;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic       lock;
    logic       en;
    logic [7:0] bus;
    logic [5:0] modid;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 1'b0;
  logic [15:0] mem_data_i = '0;
  logic [1:0]  mem_par_i = '0;
  logic [6:0]  mod_data_i = '0;
  logic [7:0]  bus_id_o;
  logic [5:0]  mod_id_o;
  logic        addr_match_en_o, out_en_o, lock_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  node_id_guard dut (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .mem_data_i(mem_data_i),
    .mem_par_i(mem_par_i), .mod_data_i(mod_data_i), .bus_id_o(bus_id_o),
    .mod_id_o(mod_id_o), .addr_match_en_o(addr_match_en_o),
    .out_en_o(out_en_o), .lock_o(lock_o)
  );

  function automatic logic [1:0] bpar(input logic [7:0] id);
    return {^id[7:4], ^id[3:0]};
  endfunction

  function automatic logic [6:0] mword(input logic [5:0] id);
    return {^id, id};
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (lock_o !== e.lock || out_en_o !== e.en || addr_match_en_o !== e.en ||
        bus_id_o !== e.bus || mod_id_o !== e.modid) begin
      errors++;
      $display("FAIL %s: lock=%0d en=%0d/%0d bus=%h mod=%h expected lock=%0d en=%0d bus=%h mod=%h",
               e.tag, lock_o, out_en_o, addr_match_en_o, bus_id_o, mod_id_o,
               e.lock, e.en, e.bus, e.modid);
    end
  endtask

  // driver: applies one cycle of stimulus, queues the outcome of the next edge
  task automatic cyc(input logic ini, input logic [7:0] b, input logic [1:0] p,
                     input logic [6:0] m, input logic el, input logic ee,
                     input logic [7:0] eb, input logic [5:0] em, input string tag);
    exp_t e;
    @(negedge clk);
    init_i     = ini;
    mem_data_i = {8'h5C, b};
    mem_par_i  = p;
    mod_data_i = m;
    e.lock = el; e.en = ee; e.bus = eb; e.modid = em; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares right after each edge that has a queued item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    int cnt = 0;
    while (cnt < 5000) begin
      @(posedge clk);
      cnt++;
    end
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1 reset state
    #1;
    compare('{lock:1'b0, en:1'b0, bus:8'h00, modid:6'h00, tag:"R1 in reset"});
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 8'h00, 2'b00, 7'h00, 0, 0, 8'h00, 6'h00, "R1 after reset");

    // good window, then normal operation
    cyc(1, 8'hA5, bpar(8'hA5), mword(6'h2B), 0, 0, 8'h00, 6'h00, "R7 loading quiet");
    cyc(1, 8'hA5, bpar(8'hA5), mword(6'h2B), 0, 0, 8'h00, 6'h00, "R7 loading quiet 2");
    cyc(0, 8'h11, 2'b11, 7'h7F, 0, 1, 8'hA5, 6'h2B, "R9 R3 R4 enter run");
    // input changes while init low: ignored, no lock on bad parity
    cyc(0, 8'h3C, 2'b01, 7'h01, 0, 1, 8'hA5, 6'h2B, "R2 ignored while low");
    cyc(0, 8'hFF, 2'b10, 7'h40, 0, 1, 8'hA5, 6'h2B, "R2 ignored while low 2");

    // re-init from run
    cyc(1, 8'h3C, bpar(8'h3C), mword(6'h15), 0, 0, 8'h00, 6'h00, "R10 enables drop");
    cyc(0, 8'h00, 2'b00, 7'h00, 0, 1, 8'h3C, 6'h15, "R9 R3 new identity");

    // bus parity error during init
    cyc(1, 8'h5A, bpar(8'h5A) ^ 2'b01, mword(6'h01), 1, 0, 8'h00, 6'h00, "R5 low half bad");
    cyc(0, 8'h5A, bpar(8'h5A), mword(6'h01), 1, 0, 8'h00, 6'h00, "R9 bad last sample");
    cyc(0, 8'h77, bpar(8'h77), mword(6'h07), 1, 0, 8'h00, 6'h00, "R8 lock holds");
    cyc(0, 8'h88, 2'b11, 7'h00, 1, 0, 8'h00, 6'h00, "R8 lock holds 2");

    // bad then good sample in one window
    cyc(1, 8'hC3, bpar(8'hC3) ^ 2'b10, mword(6'h02), 1, 0, 8'h00, 6'h00, "R11 high half bad");
    cyc(1, 8'h96, bpar(8'h96), mword(6'h21), 1, 0, 8'h00, 6'h00, "R11 lock during window");
    cyc(0, 8'h00, 2'b00, 7'h00, 0, 1, 8'h96, 6'h21, "R11 recovered");

    // module parity bad at load
    cyc(1, 8'h42, bpar(8'h42), mword(6'h33) ^ 7'h40, 0, 0, 8'h00, 6'h00, "R4 bad word loading");
    cyc(1, 8'h42, bpar(8'h42), mword(6'h33) ^ 7'h40, 1, 0, 8'h00, 6'h00, "R6 stored word bad");
    cyc(0, 8'h42, bpar(8'h42), mword(6'h33), 1, 0, 8'h00, 6'h00, "R9 stays locked");
    cyc(1, 8'h0F, bpar(8'h0F), mword(6'h3F), 1, 0, 8'h00, 6'h00, "R6 reload locked");
    cyc(0, 8'h00, 2'b00, 7'h00, 0, 1, 8'h0F, 6'h3F, "R9 clean reload");

    // single-bit upset of stored module word during run
    @(negedge clk);
    force dut.u_mod.stored_q = mword(6'h3F) ^ 7'h04;
    cyc(0, 8'h00, 2'b00, 7'h00, 1, 0, 8'h00, 6'h00, "R6 upset in run");
    @(negedge clk);
    release dut.u_mod.stored_q;
    cyc(0, 8'h0F, bpar(8'h0F), mword(6'h3F), 1, 0, 8'h00, 6'h00, "R8 after release");
    cyc(0, 8'h12, bpar(8'h12), mword(6'h12), 1, 0, 8'h00, 6'h00, "R8 after release 2");
    cyc(1, 8'h6E, bpar(8'h6E), mword(6'h2D), 1, 0, 8'h00, 6'h00, "R6 init while upset");
    cyc(0, 8'h00, 2'b00, 7'h00, 0, 1, 8'h6E, 6'h2D, "R9 upset cleared");

    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule